// File: doc/BRIEF.md
# Eight-Bit Accumulator Processor Core

This block is a compact multi-cycle processor core for a classic 8-bit accumulator architecture. It executes a subset of that architecture:
- register-to-register copies and immediate loads;
- arithmetic and logic on the accumulator with a register or memory operand;
- accumulator loads from a direct 16-bit address or through the B:C or D:E pair;
- unconditional and flag-conditioned jumps;
- a halt.

Each instruction is one, two or three bytes long. The first byte is the opcode. Any 16-bit operand arrives low byte first.

The core owns:
- seven byte registers (A, B, C, D, E, H, L);
- four flags (zero, sign, parity, carry);
- the program counter.

The core talks to a single byte-wide synchronous memory. An address presented in one cycle returns its read data in the next cycle. A write takes effect at the clock edge on which the write enable is high. Register code 110 in an operand field does not name a register: it selects the memory byte addressed by H:L.

Top module: `acc8_core`

## Requirements
- R1: While reset is low, and in the cycle after it is released, the core drives memory address 0000h with the write enable low and halted low. The program counter starts at 0000h.
- R2: The opcode is the first byte of every instruction. Immediate loads carry one data byte. Jumps and the direct load carry a 16-bit word, low byte first (C3 00 01 jumps to 0100h). The program counter moves past every byte consumed, including both address bytes of a jump that is not taken.
- R3: A move is encoded 01 DDD SSS. It copies the source into the destination and leaves the source unchanged. The register codes are B=000, C=001, D=010, E=011, H=100, L=101 and A=111. Code 110 is the memory byte at H:L.
- R4: An immediate load is encoded 00 DDD 110 and is followed by one byte. The byte goes to register DDD, or to memory at H:L when DDD is 110.
- R5: An accumulator operation is encoded 10 AAA SSS. The operations are: 000 add, 001 add with carry, 010 subtract, 011 subtract with borrow, 100 AND, 101 XOR, 110 OR and 111 compare. All but compare write the result into A. Compare leaves A unchanged.
- R6: Accumulator operations set the flags as follows:
  - zero is set when the result is 00h;
  - sign takes result bit 7;
  - parity is set when the result has an even number of ones;
  - carry is the carry out of an add, the borrow of a subtract or compare, and 0 after AND, XOR and OR.
  No other instruction changes the flags.
- R7: C3h jumps unconditionally. The pattern 11 CCC 010 jumps when its condition holds. The conditions are: 000 zero clear, 001 zero set, 010 carry clear, 011 carry set, 100 parity clear, 101 parity set, 110 sign clear and 111 sign set.
- R8: 3Ah copies into A the byte at the 16-bit operand address. 0Ah copies into A the byte addressed by B:C, and 1Ah the byte addressed by D:E. The memory source is not changed.
- R9: Opcode 76h halts the core. Halted then stays high and the core issues no further writes until reset.
- R10: Any opcode outside the subset is a one-byte no-op that leaves registers, flags and memory unchanged.
- R11: The core writes memory only through the write enable, and only at the address held in H:L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Memory byte address |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable for the current address |
| halted | output | 1 | High once a halt has executed |

## Verification
The embedded assertions check several behaviours on every cycle:
- the fetch address right after reset;
- the single-step advance of the program counter on each fetch;
- that a taken jump loads exactly the assembled operand word, and a not-taken jump leaves the counter alone;
- that compare never alters A;
- that every write goes to H:L;
- that halt is permanent and silent.

Only the bench programs can show the arithmetic results and the exact flag values for each operation, because the flags are visible only through conditional jumps. The bench reads every one of the eight conditions back after each operation, which exercises both the taken and the not-taken outcome of each condition. The same programs cover move, load and no-op semantics, and the memory-side effects of halting.

// File: rtl/acc8_core.sv
module acc8_core #(
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] mem_addr,
  input  logic [7:0]  mem_rdata,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic        halted
);

  typedef enum logic [2:0] {S_FETCH, S_DEC, S_IMM, S_LO, S_HI, S_MEM, S_HALT} state_t;

  localparam logic [2:0] CODE_M = 3'b110;
  localparam logic [2:0] CODE_A = 3'b111;

  state_t      state;
  logic [15:0] pc;
  logic [7:0]  ir, lo;
  logic [7:0]  rf [8];
  logic        fz, fs, fp, fc;

  wire [7:0]  op  = (state == S_DEC) ? mem_rdata : ir;
  wire [2:0]  dst = op[5:3];
  wire [2:0]  src = op[2:0];
  wire [15:0] hl  = {rf[4], rf[5]};
  wire [7:0]  acc = rf[CODE_A];

  wire is_halt = (op == 8'h76);
  wire is_mov  = (op[7:6] == 2'b01) && !is_halt;
  wire is_mvi  = (op[7:6] == 2'b00) && (src == CODE_M);
  wire is_lda  = (op == 8'h3A);
  wire is_ldax = (op == 8'h0A) || (op == 8'h1A);
  wire is_alu  = (op[7:6] == 2'b10);
  wire is_jmp  = (op == 8'hC3);
  wire is_jcc  = (op[7:6] == 2'b11) && (src == 3'b010);
  wire src_m   = (is_mov || is_alu) && (src == CODE_M);
  wire dst_m   = is_mov && (dst == CODE_M);

  wire [7:0] opnd = (state == S_MEM) ? mem_rdata : rf[src];

  logic [8:0] sum;
  logic       cin, take;
  always_comb begin
    cin = (dst == 3'b001 || dst == 3'b011) ? fc : 1'b0;
    case (dst)
      3'b000, 3'b001: sum = {1'b0, acc} + {1'b0, opnd} + {8'd0, cin};
      3'b100:         sum = {1'b0, acc & opnd};
      3'b101:         sum = {1'b0, acc ^ opnd};
      3'b110:         sum = {1'b0, acc | opnd};
      default:        sum = {1'b0, acc} - {1'b0, opnd} - {8'd0, cin};
    endcase
  end

  always_comb begin
    case (dst)
      3'b000:  take = !fz;
      3'b001:  take = fz;
      3'b010:  take = !fc;
      3'b011:  take = fc;
      3'b100:  take = !fp;
      3'b101:  take = fp;
      3'b110:  take = !fs;
      default: take = fs;
    endcase
  end

  wire alu_upd = is_alu && ((state == S_DEC && !src_m) || state == S_MEM);

  logic       rf_we;
  logic [2:0] rf_idx;
  logic [7:0] rf_val;
  always_comb begin
    rf_we  = 1'b0;
    rf_idx = dst;
    rf_val = opnd;
    if (alu_upd) begin
      rf_we  = (dst != CODE_A);
      rf_idx = CODE_A;
      rf_val = sum[7:0];
    end else begin
      case (state)
        S_DEC: rf_we = is_mov && !src_m && !dst_m;
        S_IMM: begin
          rf_we  = (dst != CODE_M);
          rf_val = mem_rdata;
        end
        S_MEM: begin
          rf_we  = 1'b1;
          rf_val = mem_rdata;
          if (!is_mov) rf_idx = CODE_A;
        end
        default: rf_we = 1'b0;
      endcase
    end
  end

  always_comb begin
    mem_addr  = pc;
    mem_we    = 1'b0;
    mem_wdata = 8'h00;
    case (state)
      S_DEC: begin
        if (dst_m) begin
          mem_addr  = hl;
          mem_we    = 1'b1;
          mem_wdata = rf[src];
        end else if (src_m) begin
          mem_addr = hl;
        end else if (is_ldax) begin
          mem_addr = op[4] ? {rf[2], rf[3]} : {rf[0], rf[1]};
        end
      end
      S_IMM: begin
        if (dst == CODE_M) begin
          mem_addr  = hl;
          mem_we    = 1'b1;
          mem_wdata = mem_rdata;
        end
      end
      S_HI:    mem_addr = {mem_rdata, lo};
      default: mem_addr = pc;
    endcase
  end

  assign halted = (state == S_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_FETCH;
      pc    <= RESET_PC;
      ir    <= 8'h00;
      lo    <= 8'h00;
      fz    <= 1'b0;
      fs    <= 1'b0;
      fp    <= 1'b0;
      fc    <= 1'b0;
      for (int i = 0; i < 8; i++) rf[i] <= 8'h00;
    end else begin
      if (rf_we) rf[rf_idx] <= rf_val;
      if (alu_upd) begin
        fz <= (sum[7:0] == 8'h00);
        fs <= sum[7];
        fp <= ~^sum[7:0];
        fc <= sum[8];
      end
      case (state)
        S_FETCH: begin
          pc    <= pc + 16'd1;
          state <= S_DEC;
        end
        S_DEC: begin
          ir <= mem_rdata;
          if (is_halt) begin
            state <= S_HALT;
          end else if (is_mvi) begin
            pc    <= pc + 16'd1;
            state <= S_IMM;
          end else if (is_lda || is_jmp || is_jcc) begin
            pc    <= pc + 16'd1;
            state <= S_LO;
          end else if (src_m || is_ldax) begin
            state <= S_MEM;
          end else begin
            state <= S_FETCH;
          end
        end
        S_IMM: state <= S_FETCH;
        S_LO: begin
          lo    <= mem_rdata;
          pc    <= pc + 16'd1;
          state <= S_HI;
        end
        S_HI: begin
          if (is_lda) begin
            state <= S_MEM;
          end else begin
            if (is_jmp || (is_jcc && take)) pc <= {mem_rdata, lo};
            state <= S_FETCH;
          end
        end
        S_MEM:   state <= S_FETCH;
        default: state <= S_HALT;
      endcase
    end
  end

  p_reset_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mem_addr == RESET_PC && !mem_we && !halted));

  p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FETCH) |=> (pc == $past(pc) + 16'd1));

  p_cmp_keeps_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_upd && dst == 3'b111) |=> $stable(acc));

  p_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HI && (is_jmp || (is_jcc && take))) |=> (pc == $past({mem_rdata, lo})));

  p_not_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HI && is_jcc && !take) |=> $stable(pc));

  p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !mem_we));

  p_store_hl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == hl));

endmodule

// File: tb/test_acc8_core.sv
module test_acc8_core;
  localparam int HALF_NS = 10;
  localparam int MEM_BYTES = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic        halted;

  logic [7:0] mem [MEM_BYTES];
  int total = 0;
  int bad = 0;
  int ptr = 0;

  always #HALF_NS clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[11:0]];
  end

  acc8_core i_acc8_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .halted(halted)
  );

  // {op, carry-in, A, operand}
  localparam logic [19:0] VEC [12] = '{
    {3'd0, 1'b0, 8'h3C, 8'hC4}, {3'd1, 1'b1, 8'h7F, 8'h00},
    {3'd2, 1'b0, 8'h10, 8'h20}, {3'd3, 1'b1, 8'h05, 8'h05},
    {3'd4, 1'b0, 8'hF0, 8'h3C}, {3'd5, 1'b1, 8'hAA, 8'hAA},
    {3'd6, 1'b1, 8'h01, 8'h02}, {3'd7, 1'b0, 8'h40, 8'h40},
    {3'd7, 1'b1, 8'h10, 8'h20}, {3'd1, 1'b0, 8'h12, 8'h34},
    {3'd2, 1'b1, 8'h80, 8'h01}, {3'd3, 1'b0, 8'h00, 8'h00}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic emit(input logic [7:0] b);
    mem[ptr] = b;
    ptr++;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MEM_BYTES; i++) mem[i] = 8'h00;
    ptr = 0;
  endtask

  task automatic run_prog();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 5000 && !halted; i++) @(negedge clk);
    chk("R9 program reached halt", {15'd0, halted}, 16'd1);
  endtask

  initial begin
    #(2 * HALF_NS * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    clear_mem();
    emit(8'h76);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 addr in reset", mem_addr, 16'h0000);
    chk("R1 we in reset", {15'd0, mem_we}, 16'd0);
    chk("R1 halted in reset", {15'd0, halted}, 16'd0);
    rst_n = 1'b1;
    chk("R1 first fetch addr", mem_addr, 16'h0000);
    @(negedge clk);
    @(negedge clk);
    chk("R9 halt opcode at 0000h", {15'd0, halted}, 16'd1);

    // R5 R6 R7: ALU vectors with every condition read back
    foreach (VEC[v]) begin
      logic [2:0] o;
      logic c, z, s, p, cy, e;
      logic [7:0] a, b, res, stored;
      logic [8:0] t;
      {o, c, a, b} = VEC[v];
      case (o)
        3'd0: t = {1'b0, a} + {1'b0, b};
        3'd1: t = {1'b0, a} + {1'b0, b} + {8'd0, c};
        3'd3: t = {1'b0, a} - {1'b0, b} - {8'd0, c};
        3'd4: t = {1'b0, a & b};
        3'd5: t = {1'b0, a ^ b};
        3'd6: t = {1'b0, a | b};
        default: t = {1'b0, a} - {1'b0, b};
      endcase
      res = t[7:0];
      cy = t[8];
      z = (res == 8'h00);
      s = res[7];
      p = ~^res;
      stored = (o == 3'd7) ? a : res;

      clear_mem();
      emit(8'h26); emit(8'h08);
      emit(8'h2E); emit(8'h00);
      emit(8'h3E); emit(c ? 8'hFF : 8'h00);
      emit(8'h06); emit(c ? 8'h01 : 8'h00);
      emit(8'h80);
      emit(8'h3E); emit(a);
      emit(8'h0E); emit(b);
      emit({2'b10, o, 3'b001});
      emit(8'h77);
      for (int cc = 0; cc < 8; cc++) begin
        int tgt;
        tgt = ptr + 7;
        emit(8'h3E); emit(8'h01);
        emit(8'hC2 | 8'(cc << 3)); emit(8'(tgt)); emit(8'(tgt >> 8));
        emit(8'h3E); emit(8'h00);
        emit(8'h2E); emit(8'(cc + 1));
        emit(8'h77);
      end
      emit(8'h76);
      run_prog();
      chk($sformatf("R5 vec%0d result in A", v), {8'd0, mem[12'h800]}, {8'd0, stored});
      for (int cc = 0; cc < 8; cc++) begin
        case (cc)
          0: e = !z;
          1: e = z;
          2: e = !cy;
          3: e = cy;
          4: e = !p;
          5: e = p;
          6: e = !s;
          default: e = s;
        endcase
        chk($sformatf("R6 R7 vec%0d cond%0d", v, cc), {8'd0, mem[12'h801 + cc]}, {15'd0, e});
      end
    end

    // R2 R3 R4 R8 R10 R11: directed program
    clear_mem();
    mem[12'h820] = 8'h3C;
    mem[12'h830] = 8'h99;
    mem[12'h840] = 8'h11;
    mem[12'h841] = 8'h22;
    mem[12'h842] = 8'h0A;
    emit(8'hC3); emit(8'h00); emit(8'h01);
    emit(8'h3E); emit(8'hEE); emit(8'h26); emit(8'h08); emit(8'h2E); emit(8'h50);
    emit(8'h77); emit(8'h76);
    ptr = 16'h100;
    emit(8'h26); emit(8'h08); emit(8'h2E); emit(8'h10);
    emit(8'h06); emit(8'h5A);
    emit(8'h50); emit(8'h5A); emit(8'h73);
    emit(8'h2E); emit(8'h11); emit(8'h70);
    emit(8'h2E); emit(8'h12); emit(8'h36); emit(8'hC7);
    emit(8'h2E); emit(8'h20); emit(8'h4E); emit(8'h2E); emit(8'h21); emit(8'h71);
    emit(8'h3A); emit(8'h30); emit(8'h08); emit(8'h2E); emit(8'h31); emit(8'h77);
    emit(8'h06); emit(8'h08); emit(8'h0E); emit(8'h40); emit(8'h0A);
    emit(8'h2E); emit(8'h32); emit(8'h77);
    emit(8'h16); emit(8'h08); emit(8'h1E); emit(8'h41); emit(8'h1A);
    emit(8'h2E); emit(8'h33); emit(8'h77);
    emit(8'h3E); emit(8'h05); emit(8'h2E); emit(8'h42); emit(8'h86);
    emit(8'h2E); emit(8'h34); emit(8'h77);
    emit(8'h3E); emit(8'h6B); emit(8'h07); emit(8'h00); emit(8'hFB); emit(8'h27);
    emit(8'h2E); emit(8'h35); emit(8'h77);
    emit(8'h2E); emit(8'h36); emit(8'h7D); emit(8'h77);
    emit(8'h76);
    emit(8'h3E); emit(8'hAA); emit(8'h77);
    run_prog();
    chk("R7 R2 unconditional jump skipped bad path", {8'd0, mem[12'h850]}, 16'h0000);
    chk("R3 move chain to M", {8'd0, mem[12'h810]}, 16'h005A);
    chk("R3 source unchanged", {8'd0, mem[12'h811]}, 16'h005A);
    chk("R4 immediate to M", {8'd0, mem[12'h812]}, 16'h00C7);
    chk("R3 move from M", {8'd0, mem[12'h821]}, 16'h003C);
    chk("R3 M source unchanged", {8'd0, mem[12'h820]}, 16'h003C);
    chk("R8 direct load", {8'd0, mem[12'h831]}, 16'h0099);
    chk("R8 direct source unchanged", {8'd0, mem[12'h830]}, 16'h0099);
    chk("R8 load via B:C", {8'd0, mem[12'h832]}, 16'h0011);
    chk("R8 load via D:E", {8'd0, mem[12'h833]}, 16'h0022);
    chk("R5 add with M operand", {8'd0, mem[12'h834]}, 16'h000F);
    chk("R10 unknown opcodes are no-ops", {8'd0, mem[12'h835]}, 16'h006B);
    chk("R3 move L to A", {8'd0, mem[12'h836]}, 16'h0036);

    begin
      int wr;
      wr = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (mem_we || !halted) wr++;
      end
      chk("R9 halt holds with no writes", wr[15:0], 16'd0);
      chk("R11 R9 nothing written after halt", {8'd0, mem[12'h836]}, 16'h0036);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule